// File: doc/BRIEF.md
# Pulse-Per-Second Compare Generator

This block produces a pulse-per-second strobe from a free-running system time value. Software loads a 32-bit compare word; whenever the low 32 bits of the incoming system time equal that word, the block drives a registered output pulse. The pulse lasts for a parameter-defined number of clock cycles. It also latches a sticky event flag, which can raise a level interrupt to the host when an enable bit is set. The block never advances the compare word by itself. After each pulse, firmware writes the compare value for the next second.

Software reaches the block through a minimal synchronous register port with three locations. Location 0 holds the compare word. Location 1 holds the interrupt enable. Location 2 holds the event flags: the sticky event bit, which is cleared by writing 1 to it, and a read-only copy of the live pulse level. A timer test-mode input is present, but it has no influence on the pulse path. At reset the compare word is all ones, so a system time that restarts from zero cannot produce a pulse straight after reset.

Top module: `pps_cmp_gen`

## Requirements
- R1: During and after reset the compare word reads 0xFFFF_FFFF, the interrupt enable and both event bits read 0, and `pps_out` and `irq` are 0.
- R2: A write to address 0 stores `reg_wdata` as the compare word. Address 1 bit 0 is the interrupt enable. Each location reads back the stored value, with unused bits 0. Read data appears on `reg_rdata` one clock after `reg_addr` is presented. Address 3 reads 0.
- R3: A match occurs only when `sys_time[31:0]` equals the compare word. Bits 63:32 of `sys_time` play no part.
- R4: `pps_out` rises on the clock edge that ends a match cycle. It stays high for `PULSE_CYCLES` cycles, and a further match restarts the count.
- R5: The compare word changes only through a write to address 0. A match does not change it.
- R6: Event bit 0 (address 2) is set on the same edge on which `pps_out` rises, and it stays set. Event bit 1 reads the current level of `pps_out`.
- R7: Writing 1 to address 2 bit 0 clears event bit 0, and writing 0 there leaves it unchanged. When a match and a clearing write land on the same edge, the bit stays set.
- R8: `irq` equals event bit 0 AND the interrupt enable. It is held as a level until one of the two clears.
- R9: The `test_mode` input has no effect on `pps_out` or on the event bits.
- R10: A compare write takes effect from the following cycle. A system time equal to the new value in the writing cycle itself gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_time | input | 64 | Free-running system time |
| test_mode | input | 1 | Timer test-mode flag; has no effect on the pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 compare, 1 enable, 2 events) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's address |
| pps_out | output | 1 | Pulse-per-second output |
| irq | output | 1 | Level interrupt request |

## Verification
The bench sets the low word of the system time equal to the compare value while the upper word differs. A design that compared all 64 bits would stay silent there. It also sets a time one count off the compare value, where a loose comparator would fire. It lines up a clearing write with a match on the same edge, so a design that lets the clear win loses the event. It also writes a new compare value while the time already equals it, which exposes a design that compares against the write data directly. It measures the pulse width cycle by cycle, checks the reset value of the compare word, and checks that the event bit and the interrupt stay put when a 0 is written or the test-mode input is toggled.

// File: rtl/pps_pkg.sv
package pps_pkg;

  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_CMP  = 2'd0,
    A_CTRL = 2'd1,
    A_EVT  = 2'd2,
    A_RSVD = 2'd3
  } addr_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int EVT_STICKY_BIT = 0;
  localparam int EVT_LIVE_BIT   = 1;

endpackage

// File: rtl/pps_match.sv
module pps_match #(
  parameter int TIME_W = 64,
  parameter int CMP_W  = 32
) (
  input  logic [TIME_W-1:0] sys_time,
  input  logic [CMP_W-1:0]  cmp_val,
  output logic              hit
);
  logic [CMP_W-1:0] low_word;

  generate
    if (TIME_W > CMP_W) begin : g_split
      logic [TIME_W-CMP_W-1:0] unused_high;
      assign low_word    = sys_time[CMP_W-1:0];
      assign unused_high = sys_time[TIME_W-1:CMP_W];
    end else begin : g_flat
      assign low_word = sys_time;
    end
  endgenerate

  assign hit = (low_word == cmp_val);
endmodule

// File: rtl/pps_pulse.sv
module pps_pulse #(
  parameter int PULSE_CYCLES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  output logic pulse
);
  generate
    if (PULSE_CYCLES <= 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) pulse <= 1'b0;
        else     pulse <= hit;
      end
    end else begin : g_stretch
      localparam int CNT_W = $clog2(PULSE_CYCLES);
      localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_CYCLES - 1);
      logic [CNT_W-1:0] remain;
      always_ff @(posedge clk) begin
        if (rst) begin
          pulse  <= 1'b0;
          remain <= '0;
        end else if (hit) begin
          pulse  <= 1'b1;
          remain <= LOAD;
        end else if (remain != '0) begin
          remain <= remain - 1'b1;
        end else begin
          pulse <= 1'b0;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/pps_regs.sv
module pps_regs
  import pps_pkg::*;
#(
  parameter int CMP_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CMP_W-1:0]  wdata,
  input  logic              hit,
  input  logic              pulse_live,
  output logic [CMP_W-1:0]  cmp_val,
  output logic              irq_en,
  output logic              sticky,
  output logic [CMP_W-1:0]  rdata,
  output logic              irq
);
  addr_e            sel;
  logic             clr;
  logic             sticky_d;
  logic             en_d;
  logic [CMP_W-1:0] rd_mux;

  assign sel      = addr_e'(addr);
  assign clr      = wr && (sel == A_EVT) && wdata[EVT_STICKY_BIT];
  assign sticky_d = hit || (sticky && !clr);
  assign en_d     = (wr && (sel == A_CTRL)) ? wdata[CTRL_EN_BIT] : irq_en;

  always_comb begin
    rd_mux = '0;
    case (sel)
      A_CMP:  rd_mux = cmp_val;
      A_CTRL: rd_mux[CTRL_EN_BIT] = irq_en;
      A_EVT: begin
        rd_mux[EVT_STICKY_BIT] = sticky;
        rd_mux[EVT_LIVE_BIT]   = pulse_live;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_val <= '1;
      irq_en  <= 1'b0;
      sticky  <= 1'b0;
      rdata   <= '0;
      irq     <= 1'b0;
    end else begin
      if (wr && (sel == A_CMP)) cmp_val <= wdata;
      irq_en <= en_d;
      sticky <= sticky_d;
      irq    <= sticky_d && en_d;
      rdata  <= rd_mux;
    end
  end
endmodule

// File: rtl/pps_cmp_gen.sv
module pps_cmp_gen
  import pps_pkg::*;
#(
  parameter int TIME_W       = 64,
  parameter int CMP_W        = 32,
  parameter int PULSE_CYCLES = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TIME_W-1:0] sys_time,
  input  logic              test_mode,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CMP_W-1:0]  reg_wdata,
  output logic [CMP_W-1:0]  reg_rdata,
  output logic              pps_out,
  output logic              irq
);
  logic [CMP_W-1:0] cmp_val;
  logic             hit;
  logic             irq_en;
  logic             evt_sticky;
  logic             unused_test_mode;

  assign unused_test_mode = test_mode;

  pps_match #(.TIME_W(TIME_W), .CMP_W(CMP_W)) u_match (
    .sys_time (sys_time),
    .cmp_val  (cmp_val),
    .hit      (hit)
  );

  pps_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
    .clk   (clk),
    .rst   (rst),
    .hit   (hit),
    .pulse (pps_out)
  );

  pps_regs #(.CMP_W(CMP_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr         (reg_wr),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .hit        (hit),
    .pulse_live (pps_out),
    .cmp_val    (cmp_val),
    .irq_en     (irq_en),
    .sticky     (evt_sticky),
    .rdata      (reg_rdata),
    .irq        (irq)
  );
endmodule

// File: rtl/pps_cmp_gen_chk.sv
module pps_cmp_gen_chk #(
  parameter int TIME_W = 64,
  parameter int CMP_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [TIME_W-1:0] sys_time,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic [CMP_W-1:0]  reg_wdata,
  input logic [CMP_W-1:0]  cmp_val,
  input logic              sticky,
  input logic              irq_en,
  input logic              pps_out,
  input logic              irq
);
  logic match_now;
  logic cmp_write;
  logic evt_clear;

  assign match_now = (sys_time[CMP_W-1:0] == cmp_val);
  assign cmp_write = reg_wr && (reg_addr == 2'd0);
  assign evt_clear = reg_wr && (reg_addr == 2'd2) && reg_wdata[0];

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (cmp_val == {CMP_W{1'b1}} && !pps_out && !irq && !sticky && !irq_en));

  assert_pulse_follows_R4: assert property (@(posedge clk) disable iff (rst)
    match_now |=> pps_out);

  assert_cmp_stable_R5: assert property (@(posedge clk) disable iff (rst)
    !cmp_write |=> $stable(cmp_val));

  assert_cmp_load_R10: assert property (@(posedge clk) disable iff (rst)
    cmp_write |=> (cmp_val == $past(reg_wdata)));

  assert_event_set_R6: assert property (@(posedge clk) disable iff (rst)
    match_now |=> sticky);

  assert_event_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (sticky && !evt_clear) |=> sticky);

  assert_irq_level_R8: assert property (@(posedge clk) disable iff (rst)
    irq == (sticky && irq_en));
endmodule

bind pps_cmp_gen pps_cmp_gen_chk #(.TIME_W(TIME_W), .CMP_W(CMP_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sys_time  (sys_time),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .cmp_val   (cmp_val),
  .sticky    (evt_sticky),
  .irq_en    (irq_en),
  .pps_out   (pps_out),
  .irq       (irq)
);

// File: tb/pps_cmp_gen_tb.sv
`timescale 1ns/1ps
module pps_cmp_gen_tb;
  localparam int PW = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] sys_time = '0;
  logic        test_mode = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pps_out;
  logic        irq;

  int errs = 0;
  int checks = 0;
  logic rd_req = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  pps_cmp_gen #(.PULSE_CYCLES(PW)) u_dut (
    .clk(clk), .rst(rst), .sys_time(sys_time), .test_mode(test_mode),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pps_out(pps_out), .irq(irq)
  );

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // scoreboard monitor: read results arrive one edge after the address
  always @(posedge clk) begin
    if (rd_req) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      #1;
      chk(reg_rdata, e, t);
    end
  end

  task automatic rd(input logic [1:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    reg_addr = a;
    rd_req = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1;
    reg_addr = a;
    reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // apply a matching time, then check the pulse shape over PW+1 cycles
  task automatic pulse_check(input logic [63:0] t, input string tag, input logic exp_irq);
    @(negedge clk);
    sys_time = t;
    for (int k = 0; k <= PW; k++) begin
      @(negedge clk);
      chk({31'd0, pps_out}, {31'd0, (k < PW)}, tag);
      if (k == 0) chk({31'd0, irq}, {31'd0, exp_irq}, {tag, " irq (R8)"});
      sys_time = t + 64'd1000 + 64'(k);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({30'd0, pps_out, irq}, 32'd0, "R1 pins in reset");
    rst = 1'b0;
    rd(2'd0, 32'hFFFF_FFFF, "R1 compare reset value");
    rd(2'd1, 32'd0, "R1 enable reset value");
    rd(2'd2, 32'd0, "R1 events reset value");
    for (int i = 1; i < 20; i++) begin
      @(negedge clk);
      sys_time = 64'(i);
      chk({31'd0, pps_out}, 32'd0, "R1 no pulse after reset");
    end

    wr(2'd0, 32'd100);
    rd(2'd0, 32'd100, "R2 compare readback");
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, 32'd1, "R2 enable readback");
    rd(2'd3, 32'd0, "R2 reserved reads zero");

    pulse_check({32'd5, 32'd100}, "R3 R4 low-word match", 1'b1);
    rd(2'd0, 32'd100, "R5 compare not advanced");
    rd(2'd2, 32'd1, "R6 event sticky after pulse");

    wr(2'd2, 32'd0);
    rd(2'd2, 32'd1, "R7 write 0 keeps event");
    chk({31'd0, irq}, 32'd1, "R8 irq held");
    wr(2'd2, 32'd1);
    rd(2'd2, 32'd0, "R7 write 1 clears event");
    chk({31'd0, irq}, 32'd0, "R8 irq drops with event");

    wr(2'd1, 32'd0);
    wr(2'd0, 32'd200);
    @(negedge clk); sys_time = 64'd201;
    @(negedge clk); chk({31'd0, pps_out}, 32'd0, "R3 off-by-one no match");
    pulse_check(64'd200, "R4 pulse with irq masked", 1'b0);
    chk({31'd0, irq}, 32'd0, "R8 masked irq stays low");
    wr(2'd1, 32'd1);
    chk({31'd0, irq}, 32'd1, "R8 irq on enable");
    wr(2'd2, 32'd1);

    test_mode = 1'b1;
    wr(2'd0, 32'd250);
    pulse_check(64'd250, "R9 pulse with test mode", 1'b1);
    @(negedge clk); sys_time = 64'd251;
    @(negedge clk); chk({31'd0, pps_out}, 32'd0, "R9 test mode gives no pulse");
    rd(2'd2, 32'd1, "R9 event unaffected");
    test_mode = 1'b0;
    wr(2'd2, 32'd1);
    rd(2'd2, 32'd0, "R7 cleared before race");

    wr(2'd0, 32'd300);
    @(negedge clk);
    sys_time = 64'd300; reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 32'd1;
    @(negedge clk);
    reg_wr = 1'b0; sys_time = 64'd301;
    chk({31'd0, pps_out}, 32'd1, "R4 pulse during clear race");
    repeat (PW) @(negedge clk);
    rd(2'd2, 32'd1, "R7 match wins over clear");
    wr(2'd2, 32'd1);

    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'd400; sys_time = 64'd400;
    @(negedge clk);
    reg_wr = 1'b0;
    chk({31'd0, pps_out}, 32'd0, "R10 no match in write cycle");
    @(negedge clk);
    chk({31'd0, pps_out}, 32'd1, "R10 match from next cycle");
    sys_time = 64'd401;
    @(negedge clk);
    reg_addr = 2'd2; rd_req = 1'b1;
    exp_q.push_back(32'd3); tag_q.push_back("R6 live bit during pulse");
    @(negedge clk);
    rd_req = 1'b0;
    repeat (PW) @(negedge clk);
    rd(2'd2, 32'd1, "R6 live bit low after pulse");

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(8 * 50000);
    errs++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule